// File: doc/BRIEF.md
# Peripheral Interrupt Vector Arbiter

This block sits between a group of peripheral interrupt sources and a processor core. Each source posts a one-cycle request pulse, which the block keeps as a pending flag. The block raises a single interrupt line to the core while at least one pending source is also enabled. When the core acknowledges, the block picks the enabled pending source with the highest fixed priority and clears that source's flag. In the same clock edge it stores that source's identifying offset in a read-only vector register.

The interrupt service routine reads the vector register through a small read port and branches on the value. Source i reports offset i+1, so every real source has a distinct nonzero code. The value 0000h is kept for the phantom case: an acknowledge that finds nothing pending and enabled loads zero. Software can then leave the interrupt sequence in a controlled way instead of acting on a stale code. The pending flags can also be read back through the same port.

Top module: `pirq_vector_arb`

## Requirements
- R1: After reset, all pending flags are clear, the vector register reads 0000h and the core interrupt line is low.
- R2: A request pulse on source i sets pending flag i, and that flag reads back as bit i at read address 1 from the next cycle on.
- R3: The core interrupt line is high exactly when some pending flag is set whose enable bit is also set. It falls once no such flag remains.
- R4: On acknowledge, the enabled pending source with the lowest index is selected, and the vector register at read address 0 reads index+1 from the next cycle on.
- R5: The selected source's pending flag is cleared by the same clock edge that loads its offset. All other pending flags are unchanged.
- R6: An acknowledge with no enabled pending source loads the phantom offset 0000h and leaves every pending flag unchanged.
- R7: A request that arrives in the same cycle as an acknowledge is kept pending, including a request from the source being selected.
- R8: A pending source whose enable bit is low is neither selected nor counted for the interrupt line, but it stays pending. It becomes eligible again as soon as its enable bit is set.
- R9: Read addresses other than 0 and 1 return zero.
- R10: The vector register holds its value on every cycle without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | NUM_SRC | One-cycle request pulses, one per source |
| en_i | input | NUM_SRC | Per-source enable mask |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| core_irq_o | output | 1 | Interrupt request line to the core |
| rd_addr_i | input | ADDR_W | Register read address: 0 vector, 1 pending flags |
| rd_data_o | output | OFS_W | Read data for the addressed register |

## Verification
A corrupted pending flag shows at the ports within one cycle: it appears in the pending readback, and it changes the interrupt line or the next acknowledged vector. A wrong priority chain or offset arithmetic shows up on the first acknowledge after the affected pattern. For that reason the bench walks every nonempty request pattern down to empty, one acknowledge at a time, and sweeps every enable mask against a fixed request pattern. A lost collision request, or a missing phantom load, shows on the acknowledge after the fault and no later.

// File: rtl/pirq_arb_pkg.sv
package pirq_arb_pkg;
  localparam int OFS_W = 16;
  typedef logic [OFS_W-1:0] ofs_t;
  localparam ofs_t PHANTOM_OFS = '0;
  localparam int RADDR_VEC  = 0;
  localparam int RADDR_PEND = 1;
endpackage

// File: rtl/pirq_prio_enc.sv
module pirq_prio_enc #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] cand_i,
  output logic [NUM_SRC-1:0] grant_oh_o,
  output logic [IDX_W-1:0]   grant_idx_o,
  output logic               grant_any_o
);
  logic [NUM_SRC-1:0] blocked;

  assign blocked[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < NUM_SRC; g++) begin : g_chain
      assign blocked[g] = blocked[g-1] | cand_i[g-1];
    end
    for (g = 0; g < NUM_SRC; g++) begin : g_grant
      assign grant_oh_o[g] = cand_i[g] & ~blocked[g];
    end
  endgenerate

  always_comb begin
    grant_idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant_oh_o[i]) grant_idx_o = grant_idx_o | IDX_W'(i);
    end
  end

  assign grant_any_o = |cand_i;

  always_comb begin
    assert ($onehot0(grant_oh_o)) else $error("AST_GRANT_ONEHOT"); // R4
  end
endmodule

// File: rtl/pirq_pend_bank.sv
module pirq_pend_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] clr_oh_i,
  input  logic               clr_en_i,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_SRC-1:0] pend_d;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_bit
      always_comb begin
        pend_d[g] = pend_q[g];
        if (clr_en_i && clr_oh_i[g]) pend_d[g] = 1'b0;
        if (req_i[g])                pend_d[g] = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  AST_REQ_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |=> ((pend_q & $past(req_i)) == $past(req_i))); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && (|clr_oh_i) && !(|(req_i & clr_oh_i)))
      |=> ((pend_q & $past(clr_oh_i)) == '0)); // R5

  AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> ((pend_q & ~$past(clr_oh_i)) ==
                  (($past(pend_q) | $past(req_i)) & ~$past(clr_oh_i)))); // R5
endmodule

// File: rtl/pirq_vec_reg.sv
module pirq_vec_reg
  import pirq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_i,
  input  logic             grant_any_i,
  input  logic [IDX_W-1:0] grant_idx_i,
  output ofs_t             vec_q
);
  ofs_t vec_d;
  logic vec_load;

  assign vec_load = ack_i;

  always_comb begin
    vec_d = vec_q;
    if (vec_load) begin
      if (grant_any_i) vec_d = ofs_t'(grant_idx_i) + ofs_t'(1);
      else             vec_d = PHANTOM_OFS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= PHANTOM_OFS;
    else        vec_q <= vec_d;
  end

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> $stable(vec_q)); // R10
endmodule

// File: rtl/pirq_vector_arb.sv
module pirq_vector_arb
  import pirq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 2,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               ack_i,
  output logic               core_irq_o,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [OFS_W-1:0]   rd_data_o
);
  logic               rst_meta, rst_sync_n;
  logic [NUM_SRC-1:0] pend_q, cand, grant_oh;
  logic [IDX_W-1:0]   grant_idx;
  logic               grant_any;
  ofs_t               vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pirq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_i    (req_i),
    .clr_oh_i (grant_oh),
    .clr_en_i (ack_i),
    .pend_q   (pend_q)
  );

  assign cand = pend_q & en_i;

  pirq_prio_enc #(.NUM_SRC(NUM_SRC)) u_prio (
    .cand_i      (cand),
    .grant_oh_o  (grant_oh),
    .grant_idx_o (grant_idx),
    .grant_any_o (grant_any)
  );

  pirq_vec_reg #(.NUM_SRC(NUM_SRC)) u_vec (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ack_i       (ack_i),
    .grant_any_i (grant_any),
    .grant_idx_i (grant_idx),
    .vec_q       (vec_q)
  );

  assign core_irq_o = |cand;

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_addr_i) == RADDR_VEC)       rd_data_o = vec_q;
    else if (int'(rd_addr_i) == RADDR_PEND) rd_data_o = ofs_t'(pend_q);
  end

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(core_irq_o) |-> ($past(|req_i) || !$stable(en_i))); // R3

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_i && (|(pend_q & en_i)))
      |=> (vec_q != PHANTOM_OFS && vec_q <= ofs_t'(NUM_SRC))); // R4

  AST_PHANTOM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_i && !(|(pend_q & en_i))) |=> (vec_q == PHANTOM_OFS)); // R6
endmodule

// File: tb/pirq_vector_arb_tb.sv
`timescale 1ns/1ps
module pirq_vector_arb_tb_top;
  localparam int N  = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req_i, en_i;
  logic          ack_i;
  logic          core_irq_o;
  logic [AW-1:0] rd_addr_i;
  logic [15:0]   rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [N-1:0] m_pend;
  int m_vec;

  always #4 clk = ~clk;

  pirq_vector_arb #(.NUM_SRC(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .en_i(en_i), .ack_i(ack_i),
    .core_irq_o(core_irq_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic rd(int a, output int v);
    rd_addr_i = AW'(a);
    #1;
    v = int'(rd_data_o);
  endtask

  task automatic check_state(string r);
    int v;
    rd(0, v); chk({r, " vec"}, v, m_vec);
    rd(1, v); chk({r, " pend"}, v, int'(m_pend));
    chk({r, " irq"}, int'(core_irq_o), int'(|(m_pend & en_i)));
  endtask

  task automatic pulse(logic [N-1:0] p);
    req_i = p;
    @(negedge clk);
    req_i = '0;
    m_pend = m_pend | p;
  endtask

  task automatic ack(logic [N-1:0] p);
    logic [N-1:0] c;
    c = m_pend & en_i;
    m_vec = 0;
    for (int i = N - 1; i >= 0; i--) if (c[i]) m_vec = i + 1;
    if (m_vec != 0) m_pend[m_vec-1] = 1'b0;
    m_pend = m_pend | p;
    ack_i = 1'b1; req_i = p;
    @(negedge clk);
    ack_i = 1'b0; req_i = '0;
  endtask

  task automatic drain(string r);
    while ((m_pend & en_i) != '0) begin
      ack('0);
      check_state(r);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    rst_n = 1'b0; req_i = '0; en_i = '1; ack_i = 1'b0; rd_addr_i = '0;
    m_pend = '0; m_vec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 reset");

    // R2 R3 R4 R5 R6: every nonempty pattern drained in priority order
    for (int p = 1; p < (1 << N); p++) begin
      pulse(N'(p));
      check_state("R2 set");
      drain("R4 R5 drain");
      chk("R3 irq low", int'(core_irq_o), 0);
      ack('0);
      check_state("R6 phantom");
    end

    // R8: each enable mask against a fixed pattern
    for (int m = 0; m < (1 << N); m++) begin
      en_i = N'(m);
      pulse(8'hA5);
      check_state("R8 masked");
      ack('0);
      check_state("R8 masked ack");
      en_i = '1;
      @(negedge clk);
      check_state("R8 unmask");
      drain("R8 drain");
    end

    // R7: collision of request and acknowledge
    pulse(8'h04);
    ack(8'h04);
    check_state("R7 same source");
    ack(8'h81);
    check_state("R7 other source");
    drain("R7 drain");

    // R10: vector holds while new requests arrive without acknowledge
    pulse(8'h10);
    ack('0);
    pulse(8'h02);
    repeat (3) @(negedge clk);
    check_state("R10 hold");
    drain("R10 drain");

    // R9: unused addresses read zero
    pulse(8'hFF);
    rd(2, v); chk("R9 addr2", v, 0);
    rd(3, v); chk("R9 addr3", v, 0);
    drain("R9 drain");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule